// File: doc/BRIEF.md
# Wide Ternary Search Command Sequencer

This block sits on the host side of a ternary lookup device and turns one request into a 288-bit search command. The caller presents a 288-bit key together with two 4-bit mask-pair indexes (one for the upper half of the key, one for the lower half), a 3-bit result-address prefix and a 3-bit result-register selector, and pulses `start_i` while `ready_o` is high. The sequencer then owns the command interface for four consecutive cycles, called beats A, B, C and D. In each beat it raises command-valid, drives the search opcode and places that beat's own fields on the 11-bit command bus, while a 72-bit slice of the key goes out on the data bus.

The request is captured at acceptance, so the caller may change its inputs once the first beat has started. Busy is signalled by `ready_o` low from beat A through beat D. The earliest next acceptance is the idle cycle that follows beat D. Outside a command every output bus is held at zero. The block only issues commands; it does not collect search results.

Top module: `wts_cmd_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `cmd_valid_o` is 0, `cmd_o` and `dq_o` are all zeros and `ready_o` is 1. A reset in the middle of a command abandons that command.
- R2: A request is accepted on a rising edge where `start_i` and `ready_o` are both 1. Beats A, B, C and D follow in the next four cycles. `cmd_valid_o` is 1 in all four beats, and `cmd_o[1:0]` equals binary 10 in every beat.
- R3: `dq_o` carries key bits [287:216] in beat A, [215:144] in beat B, [143:72] in beat C and [71:0] in beat D.
- R4: In beat A, `cmd_o[2]` is 1. `{cmd_o[10],cmd_o[5:3]}` equals the upper mask-pair index, and `cmd_o[9:6]` are 0.
- R5: In beat B, `cmd_o[10:2]` are all 0.
- R6: In beat C, `cmd_o[2]` is 0. `{cmd_o[10],cmd_o[5:3]}` equals the lower mask-pair index, `cmd_o[8:6]` equals the result-address prefix, and `cmd_o[9]` is 0.
- R7: In beat D, `cmd_o[8:6]` equals the result-register selector, and `cmd_o[10:9]` and `cmd_o[5:2]` are 0.
- R8: `ready_o` is 0 in beats A through D. A `start_i` raised while `ready_o` is 0 is dropped: it does not alter the command in flight and no command follows from it.
- R9: When no beat is being sent, `cmd_valid_o` is 0 and `cmd_o` and `dq_o` are all zeros.
- R10: The key and fields are sampled only at acceptance. Changing the request inputs during beats A to D does not change what is driven.
- R11: `ready_o` is 1 in the cycle after beat D. A `start_i` held high from beat D onward is accepted at the end of that idle cycle, and the new beat A follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request strobe, taken when ready_o is high |
| key_i | input | 288 | Search key |
| mask_hi_idx_i | input | 4 | Mask-pair index for key bits [287:144] |
| mask_lo_idx_i | input | 4 | Mask-pair index for key bits [143:0] |
| addr_pfx_i | input | 3 | Result-address prefix sent in beat C |
| res_reg_i | input | 3 | Result-register selector sent in beat D |
| ready_o | output | 1 | High when a new request can be accepted |
| cmd_valid_o | output | 1 | Command-valid, high during beats A to D |
| cmd_o | output | 11 | Command bus |
| dq_o | output | 72 | Data bus carrying one key slice per beat |

## Verification
The end of one command and the arrival of the next request can fall in the same cycle. A request may appear during beat D, while the block is still busy, and stay high into the idle cycle that follows. The bench provokes this by raising `start_i` with a new request during beat D and holding it. It checks that the idle cycle shows `ready_o` high with quiet buses, and that beat A of the new request appears exactly one cycle later. A separate case raises `start_i` in earlier beats and drops it before the idle cycle, and the bench checks that no extra command is issued.

// File: rtl/wts_pkg.sv
package wts_pkg;

    localparam int unsigned BEAT_CNT = 4;
    localparam int unsigned CMD_W    = 11;
    localparam int unsigned MIDX_W   = 4;
    localparam int unsigned PFX_W    = 3;
    localparam int unsigned RSEL_W   = 3;

    localparam logic [1:0] OPC_SEARCH = 2'b10;

    typedef enum logic [2:0] {
        BT_IDLE = 3'd0,
        BT_A    = 3'd1,
        BT_B    = 3'd2,
        BT_C    = 3'd3,
        BT_D    = 3'd4
    } beat_e;

    typedef struct packed {
        logic [MIDX_W-1:0] mask_hi;
        logic [MIDX_W-1:0] mask_lo;
        logic [PFX_W-1:0]  pfx;
        logic [RSEL_W-1:0] rsel;
    } side_s;

endpackage

// File: rtl/wts_beat_ctrl.sv
module wts_beat_ctrl
    import wts_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    output logic  accept_o,
    output logic  ready_o,
    output beat_e beat_o
);

    typedef struct packed {
        beat_e beat;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ready_o  = (st_q.beat == BT_IDLE);
        accept_o = ready_o && start_i;
        case (st_q.beat)
            BT_IDLE: if (accept_o) st_d.beat = BT_A;
            BT_A:    st_d.beat = BT_B;
            BT_B:    st_d.beat = BT_C;
            BT_C:    st_d.beat = BT_D;
            BT_D:    st_d.beat = BT_IDLE;
            default: st_d.beat = BT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{beat: BT_IDLE};
        else        st_q <= st_d;
    end

    assign beat_o = st_q.beat;

endmodule

// File: rtl/wts_req_hold.sv
module wts_req_hold
    import wts_pkg::*;
#(
    parameter int unsigned KEY_W = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [KEY_W-1:0] key_i,
    input  side_s            side_i,
    output logic [KEY_W-1:0] key_o,
    output side_s            side_o
);

    typedef struct packed {
        logic [KEY_W-1:0] key;
        side_s            side;
    } hold_s;

    hold_s hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (accept_i) begin
            hd_d.key  = key_i;
            hd_d.side = side_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign key_o  = hd_q.key;
    assign side_o = hd_q.side;

endmodule

// File: rtl/wts_beat_fmt.sv
module wts_beat_fmt
    import wts_pkg::*;
#(
    parameter int unsigned DQ_W = 72
) (
    input  beat_e                       beat_i,
    input  logic [DQ_W*BEAT_CNT-1:0]    key_i,
    input  side_s                       side_i,
    output logic                        valid_o,
    output logic [CMD_W-1:0]            cmd_o,
    output logic [DQ_W-1:0]             dq_o
);

    localparam int unsigned KEY_W = DQ_W * BEAT_CNT;

    // slice[0] is the most significant part of the key and goes out first
    logic [DQ_W-1:0] slice [BEAT_CNT];

    for (genvar g = 0; g < BEAT_CNT; g++) begin : g_slice
        assign slice[g] = key_i[KEY_W-1-g*DQ_W -: DQ_W];
    end

    always_comb begin
        valid_o = 1'b0;
        cmd_o   = '0;
        dq_o    = '0;
        case (beat_i)
            BT_A: begin
                valid_o    = 1'b1;
                cmd_o[1:0] = OPC_SEARCH;
                cmd_o[2]   = 1'b1;
                cmd_o[10]  = side_i.mask_hi[3];
                cmd_o[5:3] = side_i.mask_hi[2:0];
                dq_o       = slice[0];
            end
            BT_B: begin
                valid_o    = 1'b1;
                cmd_o[1:0] = OPC_SEARCH;
                dq_o       = slice[1];
            end
            BT_C: begin
                valid_o    = 1'b1;
                cmd_o[1:0] = OPC_SEARCH;
                cmd_o[10]  = side_i.mask_lo[3];
                cmd_o[5:3] = side_i.mask_lo[2:0];
                cmd_o[8:6] = side_i.pfx;
                dq_o       = slice[2];
            end
            BT_D: begin
                valid_o    = 1'b1;
                cmd_o[1:0] = OPC_SEARCH;
                cmd_o[8:6] = side_i.rsel;
                dq_o       = slice[3];
            end
            default: begin
                valid_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wts_cmd_seq.sv
module wts_cmd_seq
    import wts_pkg::*;
#(
    parameter int unsigned DQ_W = 72,
    localparam int unsigned KEY_W = DQ_W * BEAT_CNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [MIDX_W-1:0] mask_hi_idx_i,
    input  logic [MIDX_W-1:0] mask_lo_idx_i,
    input  logic [PFX_W-1:0]  addr_pfx_i,
    input  logic [RSEL_W-1:0] res_reg_i,
    output logic              ready_o,
    output logic              cmd_valid_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DQ_W-1:0]   dq_o
);

    logic             accept;
    beat_e            beat;
    side_s            side_in, side_held;
    logic [KEY_W-1:0] key_held;

    assign side_in = '{mask_hi: mask_hi_idx_i, mask_lo: mask_lo_idx_i,
                       pfx: addr_pfx_i, rsel: res_reg_i};

    wts_beat_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .ready_o  (ready_o),
        .beat_o   (beat)
    );

    wts_req_hold #(.KEY_W(KEY_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .key_i    (key_i),
        .side_i   (side_in),
        .key_o    (key_held),
        .side_o   (side_held)
    );

    wts_beat_fmt #(.DQ_W(DQ_W)) u_fmt (
        .beat_i  (beat),
        .key_i   (key_held),
        .side_i  (side_held),
        .valid_o (cmd_valid_o),
        .cmd_o   (cmd_o),
        .dq_o    (dq_o)
    );

endmodule

// File: rtl/wts_cmd_seq_chk.sv
module wts_cmd_seq_chk
    import wts_pkg::*;
#(
    parameter int unsigned DQ_W = 72
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             ready_o,
    input logic             cmd_valid_o,
    input logic [CMD_W-1:0] cmd_o,
    input logic [DQ_W-1:0]  dq_o
);

    AST_OPCODE_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_o[1:0] == OPC_SEARCH); // R2

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> (cmd_valid_o && cmd_o[2])); // R2

    AST_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && start_i) |=> cmd_valid_o ##1 cmd_valid_o ##1 cmd_valid_o
                                 ##1 (cmd_valid_o && !cmd_o[2]) ##1 !cmd_valid_o); // R2

    AST_WIDTH_MARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid_o) |-> (cmd_o[2] && cmd_o[9:6] == '0)); // R4

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> !ready_o); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid_o |-> (cmd_o == '0 && dq_o == '0)); // R9

    AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_valid_o) |-> ready_o); // R11

endmodule

bind wts_cmd_seq wts_cmd_seq_chk #(.DQ_W(DQ_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ready_o     (ready_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .dq_o        (dq_o)
);

// File: tb/wts_cmd_seq_tb.sv
module wts_cmd_seq_tb;

    localparam int DQ_W  = 72;
    localparam int KEY_W = 288;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [KEY_W-1:0]  key_i = '0;
    logic [3:0]        mask_hi_idx_i = '0;
    logic [3:0]        mask_lo_idx_i = '0;
    logic [2:0]        addr_pfx_i = '0;
    logic [2:0]        res_reg_i = '0;
    logic              ready_o;
    logic              cmd_valid_o;
    logic [10:0]       cmd_o;
    logic [DQ_W-1:0]   dq_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    wts_cmd_seq #(.DQ_W(DQ_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .key_i         (key_i),
        .mask_hi_idx_i (mask_hi_idx_i),
        .mask_lo_idx_i (mask_lo_idx_i),
        .addr_pfx_i    (addr_pfx_i),
        .res_reg_i     (res_reg_i),
        .ready_o       (ready_o),
        .cmd_valid_o   (cmd_valid_o),
        .cmd_o         (cmd_o),
        .dq_o          (dq_o)
    );

    // {key seed, upper mask idx, lower mask idx, prefix, result register}
    localparam logic [45:0] VEC [6] = '{
        {32'h0000_0001, 4'h0, 4'h0, 3'd0, 3'd0},
        {32'hDEAD_BEEF, 4'hF, 4'h0, 3'd7, 3'd1},
        {32'h1234_5678, 4'h8, 4'h7, 3'd4, 3'd3},
        {32'hA5A5_5A5A, 4'h7, 4'h8, 3'd2, 3'd6},
        {32'hFFFF_0000, 4'h5, 4'hA, 3'd5, 3'd7},
        {32'h0F0F_F0F0, 4'hC, 4'hF, 3'd1, 3'd4}
    };

    function automatic logic [KEY_W-1:0] make_key(input logic [31:0] seed);
        logic [KEY_W-1:0] k;
        for (int i = 0; i < 9; i++) k[32*i +: 32] = seed ^ (32'h9E37_79B9 * 32'(i + 1));
        return k;
    endfunction

    function automatic logic [10:0] exp_cmd(input int b, input logic [3:0] hi,
                                            input logic [3:0] lo, input logic [2:0] pfx,
                                            input logic [2:0] rs);
        logic [10:0] c;
        c = '0;
        c[1:0] = 2'b10;
        case (b)
            0: begin c[10] = hi[3]; c[5:3] = hi[2:0]; c[2] = 1'b1; end
            2: begin c[10] = lo[3]; c[5:3] = lo[2:0]; c[8:6] = pfx; end
            3: begin c[8:6] = rs; end
            default: ;
        endcase
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input logic [KEY_W-1:0] act,
                         input logic [KEY_W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(cmd_valid_o == 1'b0, {req, " valid"}, KEY_W'(cmd_valid_o), '0);
        check(cmd_o == '0, {req, " cmd"}, KEY_W'(cmd_o), '0);
        check(dq_o == '0, {req, " dq"}, KEY_W'(dq_o), '0);
        check(ready_o == 1'b1, {req, " ready"}, KEY_W'(ready_o), 1);
    endtask

    // called at a negedge with ready_o high; returns at the negedge of beat A
    task automatic launch(input logic [KEY_W-1:0] k, input logic [3:0] hi,
                          input logic [3:0] lo, input logic [2:0] pfx, input logic [2:0] rs);
        key_i = k; mask_hi_idx_i = hi; mask_lo_idx_i = lo; addr_pfx_i = pfx; res_reg_i = rs;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // mode 0: inputs scrambled during beats (R10); mode 1: also pokes start while busy (R8)
    // returns at the negedge after beat D
    task automatic check_beats(input logic [KEY_W-1:0] k, input logic [3:0] hi,
                               input logic [3:0] lo, input logic [2:0] pfx,
                               input logic [2:0] rs, input int mode);
        for (int b = 0; b < 4; b++) begin
            check(cmd_valid_o == 1'b1, "R2 valid in beat", KEY_W'(cmd_valid_o), 1);
            check(ready_o == 1'b0, "R8 ready low in beat", KEY_W'(ready_o), 0);
            check(cmd_o == exp_cmd(b, hi, lo, pfx, rs),
                  (b == 0) ? "R4 beat A cmd" : (b == 1) ? "R5 beat B cmd" :
                  (b == 2) ? "R6 beat C cmd" : "R7 beat D cmd",
                  KEY_W'(cmd_o), KEY_W'(exp_cmd(b, hi, lo, pfx, rs)));
            check(dq_o == k[KEY_W-1-b*DQ_W -: DQ_W], "R3 dq slice",
                  KEY_W'(dq_o), KEY_W'(k[KEY_W-1-b*DQ_W -: DQ_W]));
            key_i = ~k; mask_hi_idx_i = ~hi; mask_lo_idx_i = ~lo;
            addr_pfx_i = ~pfx; res_reg_i = ~rs;                       // R10
            if (mode == 1) start_i = (b < 3);                         // R8
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [KEY_W-1:0] k2;
        // R1: reset state
        repeat (2) @(negedge clk);
        check_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        // table walk: R2..R7, R10, R9 after each command
        for (int v = 0; v < 6; v++) begin
            launch(make_key(VEC[v][45:14]), VEC[v][13:10], VEC[v][9:6],
                   VEC[v][5:3], VEC[v][2:0]);
            check_beats(make_key(VEC[v][45:14]), VEC[v][13:10], VEC[v][9:6],
                        VEC[v][5:3], VEC[v][2:0], 0);
            check_idle("R9 after command");
        end

        // all-ones and all-zeros keys
        launch('1, 4'hF, 4'hF, 3'd7, 3'd7);
        check_beats('1, 4'hF, 4'hF, 3'd7, 3'd7, 0);
        check_idle("R9 after ones");
        launch('0, 4'h0, 4'h0, 3'd0, 3'd0);
        check_beats('0, 4'h0, 4'h0, 3'd0, 3'd0, 0);
        check_idle("R9 after zeros");

        // R8: start while busy is dropped, no command follows
        launch(make_key(32'h3C3C_3C3C), 4'h9, 4'h6, 3'd3, 3'd5);
        check_beats(make_key(32'h3C3C_3C3C), 4'h9, 4'h6, 3'd3, 3'd5, 1);
        check_idle("R8 idle after busy poke");
        @(negedge clk);
        check_idle("R8 no queued command");

        // R11: start raised in beat D and held, new beat A right after idle cycle
        k2 = make_key(32'h7777_1111);
        launch(make_key(32'h2468_ACE0), 4'hB, 4'h3, 3'd6, 3'd2);
        for (int b = 0; b < 3; b++) @(negedge clk);
        check(cmd_valid_o && cmd_o[8:6] == 3'd2, "R11 in beat D",
              KEY_W'(cmd_o), KEY_W'(exp_cmd(3, 4'hB, 4'h3, 3'd6, 3'd2)));
        key_i = k2; mask_hi_idx_i = 4'h1; mask_lo_idx_i = 4'hE;
        addr_pfx_i = 3'd5; res_reg_i = 3'd0; start_i = 1'b1;
        @(negedge clk);
        check_idle("R11 idle cycle between commands");
        @(negedge clk);
        start_i = 1'b0;
        check_beats(k2, 4'h1, 4'hE, 3'd5, 3'd0, 0);
        check_idle("R11 after chained command");

        // R1: reset in the middle of a command abandons it
        launch(make_key(32'h5555_AAAA), 4'h4, 4'h2, 3'd1, 3'd6);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R1 mid-command reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after mid-command reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule